// File: doc/BRIEF.md
# Up/Down Wiper Tap Controller

This block is the digital core of a 32-position digital potentiometer. Three slow control lines are brought into the system clock domain: an active-low chip select, an increment strobe and a direction line. The block then keeps a volatile tap code that steps by one position on each falling edge of the increment strobe while the chip is selected. The tap code can move up or down. It stops at either end and does not wrap.

A shadow register stands in for the nonvolatile cell and holds one tap value. If chip select is released while the increment strobe is high, the current tap code is written into the shadow register. A programming-busy interval, counted in system clocks, then starts. If chip select is released while the strobe is low, the block goes back to standby and nothing is written. The shadow register keeps its contents through reset. Every reset reloads the tap code from it, so a stored setting comes back after each restart.

The outputs are the binary tap code, a one-hot select with one bit per ladder position, a store-busy flag and a standby flag. The integrating logic drives the resistor switches from the one-hot select.

Top module: `updn_wiper_ctrl`

## Requirements
- R1: The tap code is 5 bits wide and covers 32 positions, 0 to 31. The one-hot select has exactly one bit high, and that bit's index equals the tap code.
- R2: Each falling edge of `incr` seen while `csel_n` is low moves the tap code by exactly one position.
- R3: When `dir_up` is 1 a step adds one to the tap code. When `dir_up` is 0 a step subtracts one.
- R4: An up step at code 31 leaves the code at 31, and a down step at code 0 leaves it at 0. The code never wraps.
- R5: A rising edge of `csel_n` while `incr` is high copies the tap code into the shadow register and raises `store_busy` for `BUSY_CYC` clocks.
- R6: A rising edge of `csel_n` while `incr` is low writes nothing to the shadow register and leaves `store_busy` low.
- R7: While `csel_n` is high, `standby` is 1 and strobes on `incr` or `dir_up` leave the tap code unchanged.
- R8: During reset the tap code is loaded from the shadow register. The shadow register keeps its value through reset and starts at `NV_INIT` at power-up.
- R9: While `store_busy` is high, increment edges are ignored and the tap code holds.
- R10: Each control input passes through two synchronising flops. A falling `incr` applied between clocks changes the tap code at the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the increment strobe |
| rst_n | input | 1 | Synchronous active-low reset; recalls the shadow value into the tap code |
| csel_n | input | 1 | Active-low chip select (asynchronous) |
| incr | input | 1 | Increment strobe; a falling edge steps the tap (asynchronous) |
| dir_up | input | 1 | Step direction: 1 up, 0 down (asynchronous) |
| tap_code | output | TAP_W (5) | Current binary tap position |
| tap_onehot | output | TAPS (32) | One-hot position select for the ladder switches |
| store_busy | output | 1 | High while a shadow-register write is being timed |
| standby | output | 1 | High while the synchronised chip select is deasserted |

## Verification
Some properties are checked on every clock. The one-hot select must agree with the tap code. The code may move by at most one position per clock and must never jump between 0 and 31. The tap code must hold while in standby or while busy. A store must raise the busy flag, and the shadow register must not change while busy. Other behaviour is only visible across a whole scenario, so the bench's scenarios cover it. That includes the counting and saturation under pulse trains, the exact three-edge latency, and whether a deselect stored a value or not. The bench shows the last point by resetting afterwards and looking at which code comes back.

// File: rtl/updn_pkg.sv
// Package: shared step-command type for the up/down wiper controller.
// Assumes: one step command per clock at most.
package updn_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10
    } step_cmd_t;

endpackage

// File: rtl/updn_sync2.sv
// Two-flop synchroniser for a bundle of asynchronous inputs.
// Assumes: each bit changes slowly against clk; bits are treated independently.
module updn_sync2 #(
    parameter int               W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/updn_ctl_decode.sv
// Turns synchronised control levels into step commands and store requests.
// Assumes: inputs are already synchronised; busy gates all new events.
module updn_ctl_decode
    import updn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      csel_s,
    input  logic      incr_s,
    input  logic      dir_s,
    input  logic      busy,
    output step_cmd_t step,
    output logic      store_go,
    output logic      standby
);
    logic csel_p;
    logic incr_p;
    logic inc_fall;
    logic cs_rise;

    // Previous-cycle copies for edge detection; reset to idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csel_p <= 1'b1;
            incr_p <= 1'b1;
        end else begin
            csel_p <= csel_s;
            incr_p <= incr_s;
        end
    end

    // Edge and command decode.
    always_comb begin
        inc_fall = incr_p & ~incr_s;
        cs_rise  = csel_s & ~csel_p;
        step     = STEP_NONE;
        if (!csel_s && inc_fall && !busy)
            step = dir_s ? STEP_INC : STEP_DEC;
        store_go = cs_rise & incr_s & ~busy;
        standby  = csel_s;
    end
endmodule

// File: rtl/updn_tap_counter.sv
// Saturating up/down tap register with recall-on-reset.
// Assumes: recall_val is stable during reset; at most one step per clock.
module updn_tap_counter
    import updn_pkg::*;
#(
    parameter int TAPS  = 32,
    parameter int TAP_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_cmd_t        step,
    input  logic [TAP_W-1:0] recall_val,
    output logic [TAP_W-1:0] tap
);
    localparam logic [TAP_W-1:0] TOP = TAP_W'(TAPS - 1);

    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] tap_d;

    // Next-state: saturating step.
    always_comb begin
        tap_d = tap_q;
        unique case (step)
            STEP_INC: if (tap_q != TOP)   tap_d = tap_q + 1'b1;
            STEP_DEC: if (tap_q != '0)    tap_d = tap_q - 1'b1;
            default:  tap_d = tap_q;
        endcase
    end

    // Tap register; reset recalls the shadow value.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= recall_val;
        else        tap_q <= tap_d;
    end

    assign tap = tap_q;

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tap_q == $past(tap_q)) ||
                         (tap_q == $past(tap_q) + 1'b1) ||
                         (tap_q + 1'b1 == $past(tap_q)));

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !(($past(tap_q) == TOP && tap_q == '0) ||
                           ($past(tap_q) == '0 && tap_q == TOP)));
endmodule

// File: rtl/updn_nv_shadow.sv
// Shadow of the nonvolatile cell plus a programming-busy timer.
// Assumes: the shadow value survives rst_n (power-up value NV_INIT);
// a store is accepted only while not busy.
module updn_nv_shadow #(
    parameter int TAP_W    = 5,
    parameter int BUSY_CYC = 750_000,
    parameter int NV_INIT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_go,
    input  logic [TAP_W-1:0] wr_val,
    output logic [TAP_W-1:0] nv_val,
    output logic             busy
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [TAP_W-1:0] nv_q = TAP_W'(NV_INIT);
    logic [CNT_W-1:0] cnt_q;

    // Shadow write; not cleared by reset, like a real nonvolatile cell.
    always_ff @(posedge clk) begin
        if (store_go) nv_q <= wr_val;
    end

    // Programming-busy countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (store_go)     cnt_q <= CNT_W'(BUSY_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign nv_val = nv_q;
    assign busy   = (cnt_q != '0);

    a_r5_busy_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |=> busy);

    a_r9_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(nv_q));
endmodule

// File: rtl/updn_wiper_ctrl.sv
// Top: up/down wiper tap controller for a TAPS-position potentiometer.
// Assumes: control inputs are asynchronous and far slower than clk;
// reset is synchronous, active low, and recalls the stored tap.
module updn_wiper_ctrl
    import updn_pkg::*;
#(
    parameter int TAPS     = 32,
    parameter int BUSY_CYC = 750_000,
    parameter int NV_INIT  = TAPS / 2,
    parameter int TAP_W    = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csel_n,
    input  logic             incr,
    input  logic             dir_up,
    output logic [TAP_W-1:0] tap_code,
    output logic [TAPS-1:0]  tap_onehot,
    output logic             store_busy,
    output logic             standby
);
    localparam logic [2:0] SYNC_RST = 3'b110; // csel_n, incr, dir_up idle

    logic [2:0]       sync_o;
    step_cmd_t        step;
    logic             store_go;
    logic             busy;
    logic [TAP_W-1:0] nv_val;
    logic [TAP_W-1:0] tap;

    updn_sync2 #(.W(3), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({csel_n, incr, dir_up}),
        .dout (sync_o)
    );

    updn_ctl_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .csel_s  (sync_o[2]),
        .incr_s  (sync_o[1]),
        .dir_s   (sync_o[0]),
        .busy    (busy),
        .step    (step),
        .store_go(store_go),
        .standby (standby)
    );

    updn_tap_counter #(.TAPS(TAPS), .TAP_W(TAP_W)) u_tap (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .recall_val(nv_val),
        .tap       (tap)
    );

    updn_nv_shadow #(.TAP_W(TAP_W), .BUSY_CYC(BUSY_CYC), .NV_INIT(NV_INIT)) u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_go(store_go),
        .wr_val  (tap),
        .nv_val  (nv_val),
        .busy    (busy)
    );

    // One-hot position decode, one comparator per ladder switch.
    for (genvar g = 0; g < TAPS; g++) begin : g_sel
        assign tap_onehot[g] = (tap == TAP_W'(g));
    end

    assign tap_code   = tap;
    assign store_busy = busy;

    a_r1_onehot_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_onehot) == 1) && tap_onehot[tap_code]);

    a_r7_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> $stable(tap_code));

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        store_busy |=> $stable(tap_code));
endmodule

// File: tb/sim_updn_wiper_ctrl.sv
module sim_updn_wiper_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 32;
    localparam int BUSY       = 40;

    // Vector: {dir_up[11], pulses[10:5], expected tap[4:0]}, start tap 17.
    localparam logic [11:0] VEC [8] = '{
        {1'b1, 6'd3,  5'd20},
        {1'b0, 6'd6,  5'd14},
        {1'b1, 6'd20, 5'd31},
        {1'b1, 6'd2,  5'd31},
        {1'b0, 6'd31, 5'd0},
        {1'b0, 6'd3,  5'd0},
        {1'b1, 6'd1,  5'd1},
        {1'b0, 6'd1,  5'd0}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic csel_n = 1, incr = 1, dir_up = 0;
    logic [4:0]      tap_code;
    logic [TAPS-1:0] tap_onehot;
    logic store_busy, standby;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_wiper_ctrl #(.TAPS(TAPS), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .incr(incr), .dir_up(dir_up),
        .tap_code(tap_code), .tap_onehot(tap_onehot),
        .store_busy(store_busy), .standby(standby)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_inc();
        incr = 0; wait_n(4);
        incr = 1; wait_n(4);
    endtask

    task automatic do_reset();
        rst_n = 0; wait_n(4);
        rst_n = 1; wait_n(2);
    endtask

    task automatic chk_tap(input string req, input int exp);
        chk(req, tap_code, exp);
        chk({req, " onehot R1"}, tap_onehot, longint'(1) << exp);
    endtask

    initial begin
        wait_n(1);
        do_reset();
        chk_tap("R8 power-up recall", 16);
        chk("R7 standby after reset", standby, 1);
        chk("R5 busy idle after reset", store_busy, 0);

        csel_n = 0; dir_up = 1; wait_n(4);
        chk("R7 standby low when selected", standby, 0);

        // R10 latency: fall applied at negedge, tap moves on third posedge.
        incr = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 no change after two edges", tap_code, 16);
        @(posedge clk); @(negedge clk);
        chk("R10 step on third edge R2", tap_code, 17);
        incr = 1; wait_n(4);

        // R2 R3 R4 vector walk.
        for (int i = 0; i < 8; i++) begin
            dir_up = VEC[i][11]; wait_n(3);
            for (int p = 0; p < int'(VEC[i][10:5]); p++) pulse_inc();
            chk_tap("R3 R4 vector", int'(VEC[i][4:0]));
        end

        // R6: deselect with incr low stores nothing.
        dir_up = 1; wait_n(3);
        for (int p = 0; p < 7; p++) pulse_inc();
        chk("R2 count to 7", tap_code, 7);
        incr = 0; wait_n(4);
        csel_n = 1; wait_n(6);
        chk("R6 no busy without store", store_busy, 0);
        incr = 1; wait_n(6);
        do_reset();
        chk("R6 old value recalled", tap_code, 16);

        // R5 store, R9 busy ignore, R8 recall of stored value.
        csel_n = 0; wait_n(4);
        for (int p = 0; p < 5; p++) pulse_inc();
        chk("R2 count to 21", tap_code, 21);
        csel_n = 1; wait_n(5);
        chk("R5 busy after store", store_busy, 1);
        csel_n = 0; wait_n(4);
        pulse_inc();
        chk("R9 step ignored while busy", tap_code, 21);
        chk("R5 still busy", store_busy, 1);
        csel_n = 1; wait_n(60);
        chk("R5 busy ends", store_busy, 0);
        do_reset();
        chk_tap("R8 stored value recalled", 21);

        // R7 standby ignores strobes in both directions.
        dir_up = 1; pulse_inc(); pulse_inc(); pulse_inc();
        chk("R7 up strobes ignored", tap_code, 21);
        dir_up = 0; pulse_inc(); pulse_inc();
        chk("R7 down strobes ignored", tap_code, 21);
        chk("R7 standby flag", standby, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule